// File: doc/BRIEF.md
# Sleep-Mode Entry and Exit Sequencer

This block sits in front of a synchronous memory and governs its low-power sleep state. A sleep request arrives with no timing relation to the memory clock. The block passes the request through a two-flop synchronizer and then runs a small phase machine with four phases: awake, entry window, asleep and recovery window. The entry window and the recovery window each last a fixed number of cycles.

While the memory is asleep, the block tells the access path to ignore new requests, forces the data outputs to high impedance, and enables the low-power state. Inside the entry and recovery windows the host may only deselect or read. A write offered in either window is refused and sets a sticky protocol-error flag. If the request is withdrawn before entry has finished, the machine goes straight to the recovery count.

The low-power enable follows the synchronized request rather than the phase. It is therefore removed in the same cycle that the synchronized request falls, while input blocking lasts until the recovery window begins.

Top module: `sleep_sequencer`

## Requirements
- R1: After reset the phase is awake, `in_block`, `out_hiz`, `lowpwr_en` and `proto_err` are 0, and any offered access is accepted.
- R2: `sleep_req` is sampled through a two-flop synchronizer. A request first present before clock edge k starts the entry window from edge k+2.
- R3: The entry window lasts ENTRY_CYC (default 2) cycles. If the synchronized request is still high at its end, the phase becomes asleep.
- R4: `lowpwr_en` is high only when the phase is asleep and the synchronized request is high. It falls in the first cycle the synchronized request is low, one cycle before `in_block` falls.
- R5: While asleep, `in_block` and `out_hiz` are 1 and `acc_accept` is 0 for reads and writes alike.
- R6: In the entry and recovery windows, a read (`acc_wr`=0) is accepted and a write (`acc_wr`=1) is refused.
- R7: A write refused in a window sets `proto_err` from the next cycle on, and it stays set until reset.
- R8: When the synchronized request is low in the asleep phase, a recovery window of EXIT_CYC (default 2) cycles follows, then the awake phase, where every access is accepted.
- R9: A request withdrawn during the entry window sends the phase directly to recovery, and `in_block`, `out_hiz` and `lowpwr_en` never rise.
- R10: A write offered while asleep is ignored: it is not accepted and it leaves `proto_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, high to sleep |
| acc_req | input | 1 | Host offers an access this cycle |
| acc_wr | input | 1 | Offered access is a write (1) or a read (0) |
| acc_accept | output | 1 | Offered access is taken by the memory |
| in_block | output | 1 | New accesses are ignored (asleep) |
| out_hiz | output | 1 | Data outputs forced to high impedance |
| lowpwr_en | output | 1 | Low-power state enabled |
| proto_err | output | 1 | Sticky flag: write refused in a window |

## Verification
The bench sweeps the length of the sleep pulse from one to six cycles. A one-cycle or two-cycle pulse tests the entry abort path. A three-cycle pulse reaches sleep without ever enabling low power, and longer pulses show the one-cycle lead of the low-power release over input unblocking. For each pulse length, a single write is placed at every cycle position while every other cycle offers a read. This separates the awake, window and asleep phases by the accept result. It also shows whether the error flag is raised only by window writes and not by writes while asleep.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    localparam int unsigned SEQ_CNT_W = 8;

    typedef enum logic [1:0] {
        PH_AWAKE   = 2'd0,
        PH_ENTRY   = 2'd1,
        PH_ASLEEP  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_t;

    typedef struct packed {
        phase_t                 phase;
        logic [SEQ_CNT_W-1:0]   cnt;
    } seq_state_t;

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] shift_d, shift_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb shift_d = async_in;
        end else begin : g_chain
            always_comb shift_d = {shift_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign sync_out = shift_q[STAGES-1];

    // R2: output is the input delayed by the chain, never ahead of it
    p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_out) |-> $past(shift_q[0]) || (STAGES == 1));
endmodule

// File: rtl/sleep_phase_fsm.sv
module sleep_phase_fsm
    import sleep_seq_pkg::*;
#(
    parameter int unsigned ENTRY_CYC = 2,
    parameter int unsigned EXIT_CYC  = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep_s,
    output phase_t phase,
    output logic   lowpwr_en
);
    localparam logic [SEQ_CNT_W-1:0] ENTRY_LAST = SEQ_CNT_W'(ENTRY_CYC - 1);
    localparam logic [SEQ_CNT_W-1:0] EXIT_LAST  = SEQ_CNT_W'(EXIT_CYC - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_AWAKE: begin
                if (sleep_s) begin
                    st_d.phase = PH_ENTRY;
                    st_d.cnt   = '0;
                end
            end
            PH_ENTRY: begin
                if (!sleep_s) begin
                    st_d.phase = PH_RECOVER;
                    st_d.cnt   = '0;
                end else if (st_q.cnt == ENTRY_LAST) begin
                    st_d.phase = PH_ASLEEP;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_ASLEEP: begin
                if (!sleep_s) begin
                    st_d.phase = PH_RECOVER;
                    st_d.cnt   = '0;
                end
            end
            PH_RECOVER: begin
                if (st_q.cnt == EXIT_LAST) begin
                    st_d.phase = PH_AWAKE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '{phase: PH_AWAKE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_AWAKE, cnt: '0};
        else        st_q <= st_d;
    end

    assign phase     = st_q.phase;
    assign lowpwr_en = (st_q.phase == PH_ASLEEP) && sleep_s;

    // R3: sleep is only reached through the entry window
    p_sleep_via_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ASLEEP && $past(phase) != PH_ASLEEP) |-> $past(phase) == PH_ENTRY);
    // R8: leaving sleep always enters recovery
    p_exit_to_recover_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_ASLEEP && phase != PH_ASLEEP) |-> phase == PH_RECOVER);
    // R9: entry is left either to sleep or to recovery, never straight to awake
    p_abort_to_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_ENTRY) |-> phase != PH_AWAKE);
endmodule

// File: rtl/sleep_access_gate.sv
module sleep_access_gate
    import sleep_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   acc_req,
    input  logic   acc_wr,
    output logic   acc_accept,
    output logic   proto_err
);
    typedef struct packed {
        logic err;
    } gate_state_t;

    gate_state_t g_d, g_q;
    logic in_window;
    logic win_write;

    always_comb begin
        in_window  = (phase == PH_ENTRY) || (phase == PH_RECOVER);
        win_write  = acc_req && acc_wr && in_window;
        acc_accept = acc_req && ((phase == PH_AWAKE) || (in_window && !acc_wr));
        g_d        = g_q;
        if (win_write) g_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{err: 1'b0};
        else        g_q <= g_d;
    end

    assign proto_err = g_q.err;

    // R7: the error flag never clears outside reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
    // R7: the flag only rises after a refused write in a window
    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(acc_req && acc_wr && !acc_accept
                                   && phase != PH_ASLEEP));
endmodule

// File: rtl/sleep_sequencer.sv
module sleep_sequencer
    import sleep_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ENTRY_CYC   = 2,
    parameter int unsigned EXIT_CYC    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic acc_req,
    input  logic acc_wr,
    output logic acc_accept,
    output logic in_block,
    output logic out_hiz,
    output logic lowpwr_en,
    output logic proto_err
);
    logic   sleep_s;
    phase_t phase;

    sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sleep_req),
        .sync_out (sleep_s)
    );

    sleep_phase_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_s   (sleep_s),
        .phase     (phase),
        .lowpwr_en (lowpwr_en)
    );

    sleep_access_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .acc_req    (acc_req),
        .acc_wr     (acc_wr),
        .acc_accept (acc_accept),
        .proto_err  (proto_err)
    );

    assign in_block = (phase == PH_ASLEEP);
    assign out_hiz  = (phase == PH_ASLEEP);

    // R4: low power implies the block is asleep
    p_lowpwr_in_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lowpwr_en |-> in_block);
    // R4: low power drops as soon as the synchronized request falls
    p_lowpwr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_s) |-> !lowpwr_en);
    // R5: nothing is accepted while inputs are blocked
    p_block_no_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_block |-> !acc_accept);
    // R6: writes are never taken while the data path is not fully awake
    p_window_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && phase != PH_AWAKE) |-> !acc_accept);
endmodule

// File: tb/sleep_sequencer_test.sv
module sleep_sequencer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic acc_req = 1'b0;
    logic acc_wr = 1'b0;
    logic acc_accept, in_block, out_hiz, lowpwr_en, proto_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sleep_sequencer uut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_accept(acc_accept),
        .in_block(in_block), .out_hiz(out_hiz), .lowpwr_en(lowpwr_en),
        .proto_err(proto_err)
    );

    task automatic chk(input logic act, input logic exp, input string msg);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", msg, act, exp);
        end
    endtask

    // expected phase after edge t for a pulse of w cycles: 0 awake 1 entry 2 asleep 3 recover
    function automatic int exp_phase(input int w, input int t);
        int ent_end = (w + 1 < 3) ? w + 1 : 3;
        if (t >= 2 && t <= ent_end)        return 1;
        if (t >= 4 && t <= w + 1)          return 2;
        if (t >= w + 2 && t <= w + 3)      return 3;
        return 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sleep_req = 1'b0; acc_req = 1'b0; acc_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        acc_req = 1'b1;
        #1;
        chk(in_block,   1'b0, "R1 in_block after reset");
        chk(out_hiz,    1'b0, "R1 out_hiz after reset");
        chk(lowpwr_en,  1'b0, "R1 lowpwr_en after reset");
        chk(proto_err,  1'b0, "R1 proto_err after reset");
        chk(acc_accept, 1'b1, "R1 accept after reset");

        for (int w = 1; w <= 6; w++) begin
            for (int wp = 0; wp <= w + 6; wp++) begin
                logic exp_err;
                do_reset();
                exp_err = 1'b0;
                for (int c = 0; c <= w + 6; c++) begin
                    int ph;
                    logic is_wr;
                    // negedge c precedes edge c; visible state is after edge c-1
                    @(negedge clk);
                    ph        = exp_phase(w, c - 1);
                    is_wr     = (c == wp);
                    sleep_req = (c < w);
                    acc_req   = 1'b1;
                    acc_wr    = is_wr;
                    #1;
                    chk(in_block, ph == 2, $sformatf("R5 R2 R3 R8 R9 in_block w=%0d c=%0d", w, c));
                    chk(out_hiz,  ph == 2, $sformatf("R5 R9 out_hiz w=%0d c=%0d", w, c));
                    chk(lowpwr_en, (ph == 2) && (c - 1 <= w),
                        $sformatf("R4 lowpwr_en w=%0d c=%0d", w, c));
                    if (ph == 0)
                        chk(acc_accept, 1'b1, $sformatf("R8 R1 awake accept w=%0d c=%0d", w, c));
                    else if (ph == 2)
                        chk(acc_accept, 1'b0, $sformatf("R5 R10 asleep accept w=%0d c=%0d", w, c));
                    else
                        chk(acc_accept, !is_wr, $sformatf("R6 window accept w=%0d c=%0d", w, c));
                    chk(proto_err, exp_err, $sformatf("R7 R10 proto_err w=%0d c=%0d", w, c));
                    if (is_wr && (ph == 1 || ph == 3)) exp_err = 1'b1;
                end
                @(negedge clk);
                acc_req = 1'b0;
                #1;
                chk(proto_err, exp_err, $sformatf("R7 final proto_err w=%0d wp=%0d", w, wp));
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule